// File: doc/BRIEF.md
# Cyclic Byte Buffer with Fill Counter, Level Flags and Transmit Length Tracking

This block is a twelve-entry byte queue for a contactless reader's data path. The host writes bytes that are waiting to be sent, and the receive decoder writes bytes that have just been received. Both go through one ring of storage, with a write pointer and a read pointer that wrap from the last slot back to slot zero. A fill counter always reports how many bytes are held. Three flags follow the level: a high-water flag, a low-water flag and a sticky overflow flag. A command byte on the command port empties the queue when it carries the clear code.

For sending, the host programs a length. The length is a count of whole bytes plus the number of valid bits in an optional trailing partial byte. After a start pulse, every byte taken from the queue counts toward that length. A partial final byte counts as one more byte. When the programmed amount has been taken, a transmit-done interrupt is raised.

For receiving, a frame of eight bytes or fewer produces one interrupt, at the end-of-frame pulse. A longer frame also raises an interrupt when the fill level crosses the high-water mark, so the host can empty the queue before it overflows. All interrupt sources are combined into one request line, and a clear input acknowledges them.

Top module: `byte_ring_fifo`

## Requirements
- R1: After reset, fill_count is 0, flag_low is 1, flag_high, flag_ovf, irq and every interrupt source are 0, and pop_data is 0x00.
- R2: Bytes come out in the order they were written, including when the pointers wrap from slot 11 to slot 0; 12 bytes can be held at once.
- R3: A push while fill_count is 12 is dropped and sets flag_ovf one cycle later. flag_ovf stays set until a clear command.
- R4: A pop while fill_count is 0 makes pop_data 0x00 on the next cycle and leaves the count and pointers unchanged, so later data is returned in order.
- R5: fill_count goes up by one on an accepted push and down by one on an accepted pop, visible in the cycle after the edge. It does not change when a push and a pop are both accepted in the same cycle.
- R6: flag_high is 1 exactly when fill_count is 9 or more, and flag_low is 1 exactly when fill_count is 3 or less. Both update in the same cycle as fill_count.
- R7: A command with cmd_code 0x0F empties the queue and clears flag_ovf. Any other code has no effect. The clear wins over a push or pop in the same cycle, and that push is discarded.
- R8: After tx_start, irq_tx rises in the cycle after the accepted pop that brings the drained total to len_bytes, plus one more byte when len_bits is nonzero (1 to 7). A start with a zero length raises irq_tx in the next cycle.
- R9: An rx_end pulse sets irq_rx_end. irq_rx_high is set when flag_high turns on while rx_active is 1, so a frame of 8 bytes or fewer gives only the end interrupt. Reaching 9 bytes while rx_active is 0 sets nothing.
- R10: irq is the OR of irq_tx, irq_rx_high and irq_rx_end. irq_clr clears all three, but a source that fires in the same cycle as irq_clr stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Write push_data into the queue |
| push_data | input | 8 | Byte to store |
| pop | input | 1 | Take the oldest byte |
| pop_data | output | 8 | Byte from the last pop (0x00 for an empty pop) |
| cmd_valid | input | 1 | Command byte present |
| cmd_code | input | 8 | Command byte; 0x0F empties the queue |
| len_wr | input | 1 | Load the transmit length |
| len_bytes | input | 12 | Number of whole bytes to transmit |
| len_bits | input | 3 | Valid bits in the trailing partial byte, 0 if none |
| tx_start | input | 1 | Begin counting drained bytes against the length |
| rx_active | input | 1 | A receive frame is in progress |
| rx_end | input | 1 | Pulse at the end of a received frame |
| irq_clr | input | 1 | Acknowledge all pending interrupts |
| fill_count | output | 4 | Bytes currently held |
| flag_high | output | 1 | Fill at or above 9 |
| flag_low | output | 1 | Fill at or below 3 |
| flag_ovf | output | 1 | Sticky: a push was dropped because the queue was full |
| irq_tx | output | 1 | Transmit length fully drained |
| irq_rx_high | output | 1 | High-water reached during a frame |
| irq_rx_end | output | 1 | Frame ended |
| irq | output | 1 | OR of pending interrupts |

## Verification
Several functions can fall in the same cycle. A push can meet a pop, a clear command can meet a push, an interrupt acknowledge can meet a new interrupt event, and a push can meet a pop on a full queue. The directed tasks drive these pairs in a single cycle. The checks then compare the result with the priority the requirements state: the count is unchanged when a push and a pop are both accepted, the clear discards the push, the new interrupt stays set, and on a full queue the pop succeeds while the push is dropped and flags overflow. The order of later pops shows whether a pointer moved when it should not have.

// File: rtl/ring_fifo_pkg.sv
`timescale 1ns/1ps
package ring_fifo_pkg;
  // What happened to the fill level in one cycle
  typedef enum logic [1:0] {
    LVL_HOLD = 2'b00,
    LVL_DOWN = 2'b01,
    LVL_UP   = 2'b10,
    LVL_SWAP = 2'b11
  } lvl_move_e;
endpackage

// File: rtl/ring_store.sv
`timescale 1ns/1ps
// Byte storage with a registered read port, written so it maps to block RAM
module ring_store #(
  parameter int DEPTH = 12,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  input  logic          void_rd,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q;
  logic          zero_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end

  // Marks the output as zero after reset or after a pop on an empty queue
  always_ff @(posedge clk) begin
    if (rst)               zero_q <= 1'b1;
    else if (re | void_rd) zero_q <= void_rd;
  end

  assign rdata = zero_q ? '0 : q;
endmodule

// File: rtl/ring_ctrl.sv
`timescale 1ns/1ps
// Pointers, fill counter and level flags of the ring
module ring_ctrl
  import ring_fifo_pkg::*;
#(
  parameter int DEPTH     = 12,
  parameter int HIGH_MARK = 9,
  parameter int LOW_MARK  = 3,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          rd_void,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count,
  output logic          flag_high,
  output logic          flag_low,
  output logic          flag_ovf,
  output logic          high_rise
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HI_C   = CW'(HIGH_MARK);
  localparam logic [CW-1:0] LO_C   = CW'(LOW_MARK);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          is_full, is_empty, ovf_hit;
  lvl_move_e     move;

  function automatic logic [AW-1:0] ring_next(input logic [AW-1:0] p);
    return (p == LAST_C) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    is_full  = (cnt == FULL_C);
    is_empty = (cnt == '0);
    wr_fire  = push & ~is_full  & ~clr;
    rd_fire  = pop  & ~is_empty & ~clr;
    rd_void  = pop  &  is_empty & ~clr;
    ovf_hit  = push &  is_full  & ~clr;
    move     = lvl_move_e'({wr_fire, rd_fire});
    unique case (move)
      LVL_UP:   cnt_nxt = cnt + CW'(1);
      LVL_DOWN: cnt_nxt = cnt - CW'(1);
      default:  cnt_nxt = cnt;
    endcase
    if (clr) cnt_nxt = '0;
    high_rise = (cnt_nxt >= HI_C) & ~flag_high;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      flag_high <= 1'b0;
      flag_low  <= 1'b1;
      flag_ovf  <= 1'b0;
    end else begin
      if (clr) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (wr_fire) wptr <= ring_next(wptr);
        if (rd_fire) rptr <= ring_next(rptr);
      end
      cnt       <= cnt_nxt;
      flag_high <= (cnt_nxt >= HI_C);
      flag_low  <= (cnt_nxt <= LO_C);
      if (clr)          flag_ovf <= 1'b0;
      else if (ovf_hit) flag_ovf <= 1'b1;
    end
  end

  assign waddr = wptr;
  assign raddr = rptr;
  assign count = cnt;
endmodule

// File: rtl/tx_len_track.sv
`timescale 1ns/1ps
// Counts drained bytes against a programmed length with optional partial byte
module tx_len_track #(
  parameter int LEN_W  = 12,
  parameter int PART_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic [PART_W-1:0] len_bits,
  input  logic              start,
  input  logic              drain,
  output logic              done
);
  localparam int RW = LEN_W + 1;

  logic [LEN_W-1:0]  len_b;
  logic [PART_W-1:0] len_p;
  logic [RW-1:0]     total, rem;
  logic              busy;

  always_comb begin
    total = {1'b0, len_b} + RW'(len_p != '0);
    if (start) done = (total == '0);
    else       done = busy & drain & (rem == RW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_b <= '0;
      len_p <= '0;
      rem   <= '0;
      busy  <= 1'b0;
    end else begin
      if (len_wr) begin
        len_b <= len_bytes;
        len_p <= len_bits;
      end
      if (start) begin
        rem  <= total;
        busy <= (total != '0);
      end else if (busy && drain) begin
        rem <= rem - RW'(1);
        if (rem == RW'(1)) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/byte_ring_fifo.sv
`timescale 1ns/1ps
module byte_ring_fifo #(
  parameter int          DEPTH     = 12,
  parameter int          DW        = 8,
  parameter int          HIGH_MARK = 9,
  parameter int          LOW_MARK  = 3,
  parameter int          LEN_W     = 12,
  parameter int          PART_W    = 3,
  parameter logic [7:0]  CLR_CODE  = 8'h0F,
  localparam int         CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DW-1:0]     push_data,
  input  logic              pop,
  output logic [DW-1:0]     pop_data,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic [PART_W-1:0] len_bits,
  input  logic              tx_start,
  input  logic              rx_active,
  input  logic              rx_end,
  input  logic              irq_clr,
  output logic [CW-1:0]     fill_count,
  output logic              flag_high,
  output logic              flag_low,
  output logic              flag_ovf,
  output logic              irq_tx,
  output logic              irq_rx_high,
  output logic              irq_rx_end,
  output logic              irq
);
  localparam int AW = $clog2(DEPTH);

  logic          clr, wr_fire, rd_fire, rd_void, high_rise, tx_done;
  logic [AW-1:0] waddr, raddr;
  logic          nxt_tx, nxt_hi, nxt_end;

  assign clr = cmd_valid && (cmd_code == CLR_CODE);

  ring_ctrl #(.DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK)) u_ctrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .clr(clr),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .rd_void(rd_void),
    .waddr(waddr), .raddr(raddr), .count(fill_count),
    .flag_high(flag_high), .flag_low(flag_low), .flag_ovf(flag_ovf),
    .high_rise(high_rise)
  );

  ring_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .we(wr_fire), .waddr(waddr), .wdata(push_data),
    .re(rd_fire), .raddr(raddr), .void_rd(rd_void), .rdata(pop_data)
  );

  tx_len_track #(.LEN_W(LEN_W), .PART_W(PART_W)) u_txlen (
    .clk(clk), .rst(rst), .len_wr(len_wr), .len_bytes(len_bytes),
    .len_bits(len_bits), .start(tx_start), .drain(rd_fire), .done(tx_done)
  );

  // New events win over an acknowledge in the same cycle
  always_comb begin
    nxt_tx  = (irq_tx      & ~irq_clr) | tx_done;
    nxt_hi  = (irq_rx_high & ~irq_clr) | (high_rise & rx_active);
    nxt_end = (irq_rx_end  & ~irq_clr) | rx_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx      <= 1'b0;
      irq_rx_high <= 1'b0;
      irq_rx_end  <= 1'b0;
      irq         <= 1'b0;
    end else begin
      irq_tx      <= nxt_tx;
      irq_rx_high <= nxt_hi;
      irq_rx_end  <= nxt_end;
      irq         <= nxt_tx | nxt_hi | nxt_end;
    end
  end
endmodule

// File: rtl/byte_ring_fifo_chk.sv
`timescale 1ns/1ps
module byte_ring_fifo_chk #(
  parameter int         DEPTH     = 12,
  parameter int         HIGH_MARK = 9,
  parameter logic [7:0] CLR_CODE  = 8'h0F,
  parameter int         CW        = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          push,
  input logic          pop,
  input logic [7:0]    pop_data,
  input logic          cmd_valid,
  input logic [7:0]    cmd_code,
  input logic          rx_end,
  input logic [CW-1:0] fill_count,
  input logic          flag_high,
  input logic          flag_ovf,
  input logic          irq_tx,
  input logic          irq_rx_high,
  input logic          irq_rx_end,
  input logic          irq
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HI_C   = CW'(HIGH_MARK);
  logic clr_c;
  assign clr_c = cmd_valid && (cmd_code == CLR_CODE);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    fill_count <= FULL_C);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop && !clr_c) |=> $stable(fill_count));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (push && fill_count == FULL_C && !clr_c) |=> flag_ovf);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && fill_count == '0 && !clr_c) |=> (pop_data == 8'h00));

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_c |=> (fill_count == '0 && !flag_ovf));

  assert_high_flag_R6: assert property (@(posedge clk) disable iff (rst)
    flag_high == (fill_count >= HI_C));

  assert_rx_end_R9: assert property (@(posedge clk) disable iff (rst)
    rx_end |=> irq_rx_end);

  assert_irq_merge_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_tx | irq_rx_high | irq_rx_end));
endmodule

bind byte_ring_fifo byte_ring_fifo_chk #(
  .DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK), .CLR_CODE(CLR_CODE), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .push(push), .pop(pop), .pop_data(pop_data),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .rx_end(rx_end),
  .fill_count(fill_count), .flag_high(flag_high), .flag_ovf(flag_ovf),
  .irq_tx(irq_tx), .irq_rx_high(irq_rx_high), .irq_rx_end(irq_rx_end),
  .irq(irq)
);

// File: tb/byte_ring_fifo_bench.sv
`timescale 1ns/1ps
module byte_ring_fifo_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        push, pop, cmd_valid, len_wr, tx_start, rx_active, rx_end, irq_clr;
  logic [7:0]  push_data, cmd_code, pop_data;
  logic [11:0] len_bytes;
  logic [2:0]  len_bits;
  logic [3:0]  fill_count;
  logic        flag_high, flag_low, flag_ovf, irq_tx, irq_rx_high, irq_rx_end, irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  byte_ring_fifo u_byte_ring_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .len_wr(len_wr), .len_bytes(len_bytes), .len_bits(len_bits),
    .tx_start(tx_start), .rx_active(rx_active), .rx_end(rx_end),
    .irq_clr(irq_clr), .fill_count(fill_count), .flag_high(flag_high),
    .flag_low(flag_low), .flag_ovf(flag_ovf), .irq_tx(irq_tx),
    .irq_rx_high(irq_rx_high), .irq_rx_end(irq_rx_end), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_push(input logic [7:0] b);
    push = 1'b1; push_data = b; step(); push = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1; step(); pop = 1'b0;
  endtask

  task automatic do_cmd(input logic [7:0] c);
    cmd_valid = 1'b1; cmd_code = c; step(); cmd_valid = 1'b0;
  endtask

  task automatic do_ack();
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", fill_count, 0);
    check("R1 low", flag_low, 1);
    check("R1 high", flag_high, 0);
    check("R1 ovf", flag_ovf, 0);
    check("R1 irq", {irq, irq_tx, irq_rx_high, irq_rx_end}, 0);
    check("R1 data", pop_data, 8'h00);
  endtask

  task automatic t_order_wrap();
    for (int i = 0; i < 5; i++) begin
      do_push(8'h10 + 8'(i));
      check("R5 count up", fill_count, i + 1);
    end
    for (int i = 0; i < 5; i++) begin
      do_pop();
      check("R2 order", pop_data, 8'h10 + 8'(i));
    end
    // Pointers now start at slot 5, so twelve pushes wrap
    for (int i = 0; i < 12; i++) begin
      do_push(8'hA0 + 8'(i));
      check("R6 low", flag_low, (i + 1) <= 3);
      check("R6 high", flag_high, (i + 1) >= 9);
    end
    check("R2 full count", fill_count, 12);
    for (int i = 0; i < 12; i++) begin
      do_pop();
      check("R2 wrap order", pop_data, 8'hA0 + 8'(i));
      check("R5 count down", fill_count, 11 - i);
    end
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 12; i++) do_push(8'h40 + 8'(i));
    do_push(8'hEE);
    check("R3 count", fill_count, 12);
    check("R3 ovf set", flag_ovf, 1);
    for (int i = 0; i < 12; i++) do_pop();
    check("R3 dropped byte absent", pop_data, 8'h4B);
    check("R3 ovf sticky", flag_ovf, 1);
    do_pop();
    check("R3 nothing after last", pop_data, 8'h00);
    do_cmd(8'h0F);
    check("R7 ovf cleared", flag_ovf, 0);
  endtask

  task automatic t_empty_read();
    do_push(8'h77);
    do_pop();
    check("R4 prior data", pop_data, 8'h77);
    do_pop();
    check("R4 empty data", pop_data, 8'h00);
    check("R4 empty count", fill_count, 0);
    do_push(8'h55);
    do_push(8'h56);
    do_pop();
    check("R4 order kept", pop_data, 8'h55);
    do_pop();
    check("R4 order kept 2", pop_data, 8'h56);
  endtask

  task automatic t_same_cycle();
    do_push(8'h01); do_push(8'h02); do_push(8'h03);
    push = 1'b1; pop = 1'b1; push_data = 8'h04; step(); push = 1'b0; pop = 1'b0;
    check("R5 swap count", fill_count, 3);
    check("R5 swap data", pop_data, 8'h01);
    do_cmd(8'h0F);
    // Push and pop on an empty queue: pop yields zero, push lands
    push = 1'b1; pop = 1'b1; push_data = 8'h99; step(); push = 1'b0; pop = 1'b0;
    check("R4 empty swap data", pop_data, 8'h00);
    check("R5 empty swap count", fill_count, 1);
    do_pop();
    check("R4 empty swap stored", pop_data, 8'h99);
    for (int i = 0; i < 12; i++) do_push(8'hC0 + 8'(i));
    push = 1'b1; pop = 1'b1; push_data = 8'hDD; step(); push = 1'b0; pop = 1'b0;
    check("R3 full swap count", fill_count, 11);
    check("R3 full swap ovf", flag_ovf, 1);
    check("R3 full swap data", pop_data, 8'hC0);
    do_cmd(8'h0F);
  endtask

  task automatic t_clear();
    for (int i = 0; i < 4; i++) do_push(8'h20 + 8'(i));
    do_cmd(8'h0E);
    check("R7 other code ignored", fill_count, 4);
    do_pop();
    check("R7 other code data", pop_data, 8'h20);
    cmd_valid = 1'b1; cmd_code = 8'h0F; push = 1'b1; push_data = 8'h33;
    step();
    cmd_valid = 1'b0; push = 1'b0;
    check("R7 clear wins", fill_count, 0);
    check("R7 clear low", flag_low, 1);
    do_pop();
    check("R7 push discarded", pop_data, 8'h00);
  endtask

  task automatic t_tx();
    len_wr = 1'b1; len_bytes = 12'd2; len_bits = 3'd3; step(); len_wr = 1'b0;
    for (int i = 0; i < 4; i++) do_push(8'h60 + 8'(i));
    tx_start = 1'b1; step(); tx_start = 1'b0;
    do_pop(); do_pop();
    check("R8 not yet", irq_tx, 0);
    do_pop();
    check("R8 partial byte counted", irq_tx, 1);
    check("R10 irq from tx", irq, 1);
    do_ack();
    check("R10 ack clears", {irq, irq_tx}, 0);
    do_cmd(8'h0F);
    len_wr = 1'b1; len_bytes = 12'd2; len_bits = 3'd0; step(); len_wr = 1'b0;
    do_push(8'h01); do_push(8'h02); do_push(8'h03);
    tx_start = 1'b1; step(); tx_start = 1'b0;
    do_pop();
    check("R8 whole bytes first", irq_tx, 0);
    do_pop();
    check("R8 whole bytes done", irq_tx, 1);
    do_ack();
    len_wr = 1'b1; len_bytes = 12'd0; len_bits = 3'd0; step(); len_wr = 1'b0;
    tx_start = 1'b1; step(); tx_start = 1'b0;
    check("R8 zero length", irq_tx, 1);
    do_ack();
    do_cmd(8'h0F);
  endtask

  task automatic t_rx();
    rx_active = 1'b1;
    for (int i = 0; i < 8; i++) do_push(8'h80 + 8'(i));
    check("R9 short no high irq", irq_rx_high, 0);
    rx_end = 1'b1; step(); rx_end = 1'b0;
    rx_active = 1'b0;
    check("R9 end irq", irq_rx_end, 1);
    check("R9 short single irq", irq_rx_high, 0);
    do_ack(); do_cmd(8'h0F);
    rx_active = 1'b1;
    for (int i = 0; i < 8; i++) do_push(8'h90 + 8'(i));
    check("R9 eight no irq", irq, 0);
    do_push(8'h98);
    check("R9 high irq", irq_rx_high, 1);
    check("R10 irq from rx", irq, 1);
    // Acknowledge together with an end pulse: the end source stays
    irq_clr = 1'b1; rx_end = 1'b1; step(); irq_clr = 1'b0; rx_end = 1'b0;
    rx_active = 1'b0;
    check("R10 ack clears high", irq_rx_high, 0);
    check("R10 set wins", irq_rx_end, 1);
    do_ack(); do_cmd(8'h0F);
    for (int i = 0; i < 9; i++) do_push(8'h00 + 8'(i));
    check("R9 idle high flag", flag_high, 1);
    check("R9 idle no irq", irq_rx_high, 0);
    do_cmd(8'h0F);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; push = 1'b0; pop = 1'b0; cmd_valid = 1'b0; len_wr = 1'b0;
    tx_start = 1'b0; rx_active = 1'b0; rx_end = 1'b0; irq_clr = 1'b0;
    push_data = 8'h00; cmd_code = 8'h00; len_bytes = '0; len_bits = '0;
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_order_wrap();
    t_overflow();
    t_empty_read();
    t_same_cycle();
    t_clear();
    t_tx();
    t_rx();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule